// File: doc/BRIEF.md
# Packed Horizontal Pair Add/Subtract Unit

This block is a SIMD datapath stage that reduces neighbouring elements of a 128-bit vector. It takes two 128-bit operands. Each result lane is formed from two adjacent elements of one operand: element 2k and element 2k+1. Every result lane is therefore a horizontal reduction of one operand, and the two operands are never combined lane by lane. Pairs taken from the first operand fill the low half of the result, and pairs taken from the second operand fill the high half.

The unit works on two lane sizes: 16-bit elements, which give eight results, and 32-bit elements, which give four results. It can add or subtract. Subtraction always takes the odd element away from the even element. In 16-bit mode, results can either wrap or clamp to the signed 16-bit range. In 32-bit mode, results always wrap.

Operands and the opcode enter through a valid/ready handshake. The result leaves through a second valid/ready handshake, after a single output register.

Top module: `hpair_unit`

## Requirements
- R1: In 16-bit mode, lane k of `result` occupies bits [16k+15:16k]. For k in 0..3, lane k is computed from `opA` elements 2k and 2k+1, where element i is bits [16i+15:16i].
- R2: In 32-bit mode (`wide`=1), lanes 0 and 1 (bits [63:0]) are computed from `opA` element pairs (0,1) and (2,3). Lanes 2 and 3 are computed from the same pairs of `opB`. Element i is bits [32i+31:32i].
- R3: Subtract operations give the even-indexed element minus the odd-indexed element of each pair, with all elements treated as two's-complement signed values.
- R4: The 16-bit saturating operations clamp each lane to the range -32768..32767.
- R5: The 16-bit non-saturating operations keep the low 16 bits of the exact result, so they wrap modulo 2^16. In 16-bit mode, lanes 4..7 are computed from the same pairs of `opB`.
- R6: In 32-bit mode, results wrap modulo 2^32. The saturate bit of `opSel` has no effect in this mode.
- R7: While `rstN` is low, `outValid` is 0.
- R8: `inReady` is high whenever `outValid` is 0 or `outReady` is 1. A transfer happens when `inValid` and `inReady` are both high. The result of a transfer appears with `outValid`=1 on the next clock edge. When the output is accepted and no new transfer happens, `outValid` drops.
- R9: While `outValid`=1 and `outReady`=0, `result` and `outValid` hold their values.
- R10: `opSel` encodes the operation: 2'b00 add, 2'b01 add-saturate, 2'b10 subtract, 2'b11 subtract-saturate. Bit 1 selects subtract and bit 0 selects saturate. `wide`=0 selects 16-bit lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and opcode are present |
| inReady | output | 1 | Unit can accept operands this cycle |
| opSel | input | 2 | Operation: bit 1 subtract, bit 0 saturate |
| wide | input | 1 | 1 = 32-bit lanes, 0 = 16-bit lanes |
| opA | input | 128 | First operand, supplies the low-half results |
| opB | input | 128 | Second operand, supplies the high-half results |
| outValid | output | 1 | `result` holds an unconsumed value |
| outReady | input | 1 | Downstream accepts the result |
| result | output | 128 | Packed pairwise results |

## Verification
`inReady` depends only on the current `outValid` and `outReady`, so it is due in the same cycle as the inputs that produce it. The bench samples it shortly after driving those inputs and before the clock edge. A result accepted at one clock edge is due at the output after exactly that single edge.

The bench model updates its expected valid flag and expected result at the same edge. It then compares `outValid` and `result` against them at the following falling edge, on every cycle, including cycles where the output is stalled and must hold.

// File: rtl/hpair_pkg.sv
package hpair_pkg;

  // Strobes driven by the control block into the datapath
  typedef struct packed {
    logic load;       // capture the operands into the output register
    logic subtract;   // even element minus odd element
    logic saturate;   // clamp narrow lanes (never set for wide lanes)
    logic wideMode;   // 32-bit lane view
  } dpStrobe_t;

  localparam int OP_W = 2;

endpackage

// File: rtl/hpair_lane.sv
module hpair_lane #(
  parameter int LANE_W = 16,
  parameter bit SAT_EN = 1'b1
) (
  input  logic [LANE_W-1:0] elemEven,
  input  logic [LANE_W-1:0] elemOdd,
  input  logic              subtract,
  input  logic              saturate,
  output logic [LANE_W-1:0] laneOut
);

  localparam int EXT_W = LANE_W + 1;

  logic [EXT_W-1:0] extEven;
  logic [EXT_W-1:0] extOdd;
  logic [EXT_W-1:0] exact;
  logic             overflow;
  logic [LANE_W-1:0] clampVal;

  assign extEven = {elemEven[LANE_W-1], elemEven};
  assign extOdd  = {elemOdd[LANE_W-1], elemOdd};
  assign exact   = subtract ? (extEven - extOdd) : (extEven + extOdd);

  // The exact result fits in LANE_W bits when the two top bits agree
  assign overflow = exact[EXT_W-1] ^ exact[LANE_W-1];
  assign clampVal = exact[EXT_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                   : {1'b0, {(LANE_W-1){1'b1}}};

  generate
    if (SAT_EN) begin : g_sat
      assign laneOut = (saturate && overflow) ? clampVal : exact[LANE_W-1:0];
    end else begin : g_wrap
      logic unusedSat;
      assign unusedSat = saturate ^ overflow ^ clampVal[0];
      assign laneOut = exact[LANE_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/hpair_ctrl.sv
module hpair_ctrl
  import hpair_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            outReady,
  input  logic [OP_W-1:0] opSel,
  input  logic            wide,
  output logic            inReady,
  output logic            outValid,
  output dpStrobe_t       strobe
);

  logic validQ;
  logic loadNow;

  assign inReady = !validQ || outReady;
  assign loadNow = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (loadNow) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.load     = loadNow;
    strobe.subtract = opSel[1];
    strobe.saturate = opSel[0] && !wide;
    strobe.wideMode = wide;
  end

  assign outValid = validQ;

endmodule

// File: rtl/hpair_dp.sv
module hpair_dp
  import hpair_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] result
);

  localparam int N_LANES = VEC_W / NARROW_W;
  localparam int N_HALF  = N_LANES / 2;
  localparam int W_LANES = VEC_W / WIDE_W;
  localparam int W_HALF  = W_LANES / 2;

  logic [VEC_W-1:0] narrowRes;
  logic [VEC_W-1:0] wideRes;
  logic [VEC_W-1:0] resultQ;

  // Narrow lanes: low half from opA, high half from opB
  for (genvar k = 0; k < N_LANES; k++) begin : g_narrow
    localparam int PAIR = (k % N_HALF) * 2;
    logic [NARROW_W-1:0] eEven;
    logic [NARROW_W-1:0] eOdd;
    if (k < N_HALF) begin : g_srcA
      assign eEven = opA[PAIR*NARROW_W +: NARROW_W];
      assign eOdd  = opA[(PAIR+1)*NARROW_W +: NARROW_W];
    end else begin : g_srcB
      assign eEven = opB[PAIR*NARROW_W +: NARROW_W];
      assign eOdd  = opB[(PAIR+1)*NARROW_W +: NARROW_W];
    end
    hpair_lane #(.LANE_W(NARROW_W), .SAT_EN(1'b1)) u_lane (
      .elemEven (eEven),
      .elemOdd  (eOdd),
      .subtract (strobe.subtract),
      .saturate (strobe.saturate),
      .laneOut  (narrowRes[k*NARROW_W +: NARROW_W])
    );
  end

  // Wide lanes: wrap only
  for (genvar k = 0; k < W_LANES; k++) begin : g_wide
    localparam int PAIR = (k % W_HALF) * 2;
    logic [WIDE_W-1:0] eEven;
    logic [WIDE_W-1:0] eOdd;
    if (k < W_HALF) begin : g_srcA
      assign eEven = opA[PAIR*WIDE_W +: WIDE_W];
      assign eOdd  = opA[(PAIR+1)*WIDE_W +: WIDE_W];
    end else begin : g_srcB
      assign eEven = opB[PAIR*WIDE_W +: WIDE_W];
      assign eOdd  = opB[(PAIR+1)*WIDE_W +: WIDE_W];
    end
    hpair_lane #(.LANE_W(WIDE_W), .SAT_EN(1'b0)) u_lane (
      .elemEven (eEven),
      .elemOdd  (eOdd),
      .subtract (strobe.subtract),
      .saturate (1'b0),
      .laneOut  (wideRes[k*WIDE_W +: WIDE_W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobe.load) begin
      resultQ <= strobe.wideMode ? wideRes : narrowRes;
    end
  end

  assign result = resultQ;

endmodule

// File: rtl/hpair_unit.sv
module hpair_unit
  import hpair_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [OP_W-1:0]  opSel,
  input  logic             wide,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic             outValid,
  input  logic             outReady,
  output logic [VEC_W-1:0] result
);

  dpStrobe_t strobe;

  hpair_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .opSel    (opSel),
    .wide     (wide),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  hpair_dp #(
    .VEC_W    (VEC_W),
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/hpair_unit_chk.sv
module hpair_unit_chk (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         inReady,
  input logic [1:0]   opSel,
  input logic         wide,
  input logic [127:0] opA,
  input logic         outValid,
  input logic         outReady,
  input logic [127:0] result
);

  logic xfer;
  assign xfer = inValid && inReady;

  // R7
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_idle_r7: assert (!outValid);
    end
  end

  p_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    xfer |=> outValid);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  p_drain_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(result)));

  p_sub_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && opSel[1] && !wide && (opA[15:0] == opA[31:16]))
      |=> (result[15:0] == 16'h0000));

  p_add_ident_r1: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && (opSel == 2'b00) && !wide && (opA[31:16] == 16'h0000))
      |=> (result[15:0] == $past(opA[15:0])));

  p_sat_pos_r4: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && (opSel == 2'b01) && !wide && !opA[15] && !opA[31])
      |=> !result[15]);

  p_wide_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && wide && (opA[63:32] == 32'h0))
      |=> (result[31:0] == $past(opA[31:0])));

endmodule

bind hpair_unit hpair_unit_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .opSel    (opSel),
  .wide     (wide),
  .opA      (opA),
  .outValid (outValid),
  .outReady (outReady),
  .result   (result)
);

// File: tb/hpair_unit_test.sv
module hpair_unit_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [1:0]   opSel = 2'b00;
  logic         wide = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [127:0] result;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // behavioural model state
  bit           mVld = 1'b0;
  logic [127:0] mRes = '0;
  string        mTag = "R1";

  always #5 clk = ~clk;

  hpair_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opSel(opSel), .wide(wide), .opA(opA), .opB(opB),
    .outValid(outValid), .outReady(outReady), .result(result)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] refModel(input logic [1:0] op, input logic w,
                                            input logic [127:0] a,
                                            input logic [127:0] b);
    logic [127:0] r;
    r = '0;
    if (!w) begin
      for (int k = 0; k < 8; k++) begin
        logic [127:0] src;
        int j, x0, x1, s;
        src = (k < 4) ? a : b;
        j = k % 4;
        x0 = int'($signed(src[32*j +: 16]));
        x1 = int'($signed(src[32*j+16 +: 16]));
        s = op[1] ? (x0 - x1) : (x0 + x1);
        if (op[0]) begin
          if (s > 32767) s = 32767;
          if (s < -32768) s = -32768;
        end
        r[16*k +: 16] = s[15:0];
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        logic [127:0] src;
        int j;
        longint y0, y1, t;
        src = (k < 2) ? a : b;
        j = k % 2;
        y0 = longint'($signed(src[64*j +: 32]));
        y1 = longint'($signed(src[64*j+32 +: 32]));
        t = op[1] ? (y0 - y1) : (y0 + y1);
        r[32*k +: 32] = t[31:0];
      end
    end
    return r;
  endfunction

  function automatic string tagOf(input logic [1:0] op, input logic w);
    if (w) return "R2 R6 R10";
    case (op)
      2'b00:   return "R1 R5 R10";
      2'b01:   return "R1 R4 R10";
      2'b10:   return "R3 R5 R10";
      default: return "R3 R4 R10";
    endcase
  endfunction

  // One clock: drive after the falling edge, check inReady before the
  // rising edge, advance the model at that edge, compare at the next fall.
  task automatic step(input bit v, input bit rdy, input logic [1:0] op,
                      input logic w, input logic [127:0] a, input logic [127:0] b);
    bit expReady;
    inValid = v; outReady = rdy; opSel = op; wide = w; opA = a; opB = b;
    #1;
    expReady = !mVld || rdy;
    check(inReady == expReady, "R8 inReady", {127'b0, inReady}, {127'b0, expReady});
    if (v && expReady) begin
      mVld = 1'b1;
      mRes = refModel(op, w, a, b);
      mTag = tagOf(op, w);
    end else if (rdy) begin
      mVld = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(outValid == mVld, "R8 R9 outValid", {127'b0, outValid}, {127'b0, mVld});
    if (mVld) check(result == mRes, mTag, result, mRes);
  endtask

  function automatic logic [127:0] pack16(input logic [15:0] x);
    return {8{x}};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R7 reset outValid", {127'b0, outValid}, 128'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R7 idle after reset", {127'b0, outValid}, 128'h0);

    // Boundary values, every opcode, both widths
    for (int w = 0; w < 2; w++) begin
      for (int op = 0; op < 4; op++) begin
        step(1, 1, op[1:0], w[0], pack16(16'h7fff), pack16(16'h8000));
        step(1, 1, op[1:0], w[0], {8{16'h8000, 16'h7fff}}, {8{16'h0001, 16'h8000}});
        step(1, 1, op[1:0], w[0], {4{32'h80000000}}, {4{32'h7fffffff}});
        step(1, 1, op[1:0], w[0], {4{32'h00000001, 32'h80000000}}, {4{32'hffffffff}});
        step(1, 1, op[1:0], w[0], {8{16'hffff}}, 128'h0);
        step(1, 1, op[1:0], w[0], rnd128(), rnd128());
      end
    end

    // R9: stall with a full register, new offers must not disturb it
    step(1, 0, 2'b00, 1'b0, rnd128(), rnd128());
    for (int i = 0; i < 4; i++) step(1, 0, 2'b10, 1'b1, rnd128(), rnd128());
    step(0, 1, 2'b00, 1'b0, '0, '0);
    step(0, 1, 2'b00, 1'b0, '0, '0);

    // Random traffic with random backpressure
    for (int i = 0; i < 600; i++) begin
      logic [127:0] a, b;
      a = rnd128();
      b = rnd128();
      if (($urandom % 4) == 0) a[15:0] = 16'h8000;
      if (($urandom % 4) == 0) b[63:32] = 32'h80000000;
      step(($urandom % 3) != 0, ($urandom % 3) != 0,
           2'($urandom), 1'($urandom), a, b);
    end
    step(0, 1, 2'b00, 1'b0, '0, '0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule